// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the date as packed BCD values and advances them once for every cycle in which the one-second enable is high. It tracks seconds, minutes, hours, day of week, day of month, month and two-digit year. A century flag sits above the year. The hour can be encoded in 24-hour form or in 12-hour form with an afternoon marker. February length follows a leap rule in which every year divisible by four is a leap year. That rule is valid for the span 2000 to 2099.

A host reaches every field through a byte-wide register port. A write lands on the next clock edge. A read is combinational from the selected address. The one-second enable comes from outside the block, and no oscillator, trim or serial bus logic lives here.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset, reading the registers gives: seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01 with century clear, year 0x00, control 0x00 (24-hour mode).
- R2: Seconds (address 0) and minutes (address 1) count in BCD 00 to 59. They advance only on a cycle with `tick` high. A seconds wrap from 59 to 00 carries into minutes. Without a tick, every field holds its value.
- R3: In 24-hour mode (control bit 0 = 0), the hour at address 2 counts BCD 00 to 23. A minutes carry at hour 23 wraps it to 00 and carries into the date.
- R4: In 12-hour mode (control bit 0 = 1), the hour bits 4:0 hold BCD 01 to 12 and bit 5 is the PM marker. The sequence is 12, 01 … 11. Going from 11 to 12 flips the marker. Going from 11 PM (0x31) to 12 AM (0x12) carries into the date.
- R5: The weekday at address 3 counts 0 to 6 on each date carry and wraps from 6 to 0.
- R6: The day of month at address 4 wraps to 01 after the last day of its month. The last day is 30 for April, June, September and November, and 31 for the other months except February.
- R7: February ends on day 29 when the BCD year is divisible by four, including year 00, and on day 28 otherwise.
- R8: The month at address 5 (bits 4:0, BCD 01 to 12) wraps from 12 to 01 and carries into the year at address 6. The year wraps from 99 to 00 and, in that same tick, flips the century flag at address 5 bit 7.
- R9: A host write (`wr_en`, `addr`, `wdata`) loads the addressed field on the next clock edge. When a write and a tick fall in the same cycle, the write is applied and that tick is discarded in full, so no field advances.
- R10: Reads are combinational. Address 7 bit 0 reads back the 12-hour mode bit, and unused upper bits of each field read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
The hardest state to reach is a single tick that ripples through every field at once: 23:59:59, or 11:59:59 PM in 12-hour mode, on the last day of a month, where the month end also ends the year and the century. Counting up to that state from reset would take decades of ticks. Instead, the stimulus loads each field through the write port just before one tick and then reads back every field. A vector table covers the month lengths, the leap years on both sides of the divisible-by-four rule, both century directions and the 12-hour transitions. Directed cases cover a write that collides with a tick.

// File: rtl/bcd_clock_core.sv
module bcd_clock_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [6:0] sec, min;
  logic [5:0] hr;
  logic [2:0] wday;
  logic [5:0] mday;
  logic [4:0] mon;
  logic       cen;
  logic [7:0] yr;
  logic       h12;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcd_inc = {v[7:4] + 4'd1, 4'h0};
    else                bcd_inc = v + 8'd1;
  endfunction

  logic [7:0] sec_i, min_i, hr24_i, hr12_i, mday_i, mon_i, yr_i;
  assign sec_i  = bcd_inc({1'b0, sec});
  assign min_i  = bcd_inc({1'b0, min});
  assign hr24_i = bcd_inc({2'b0, hr});
  assign hr12_i = bcd_inc({3'b0, hr[4:0]});
  assign mday_i = bcd_inc({2'b0, mday});
  assign mon_i  = bcd_inc({3'b0, mon});
  assign yr_i   = bcd_inc(yr);

  logic sec_wrap, min_cy, day_cy, mon_cy, yr_cy, yr_wrap, leap, mday_end;
  logic [5:0] hr_nx, mlast;

  assign sec_wrap = (sec == 7'h59);
  assign min_cy   = sec_wrap && (min == 7'h59);
  assign day_cy   = min_cy && (h12 ? (hr == 6'h31) : (hr == 6'h23));

  always_comb begin
    if (h12) begin
      if (hr[4:0] == 5'h12)      hr_nx = {hr[5], 5'h01};
      else if (hr[4:0] == 5'h11) hr_nx = {~hr[5], 5'h12};
      else                       hr_nx = {hr[5], hr12_i[4:0]};
    end else begin
      hr_nx = (hr == 6'h23) ? 6'h00 : hr24_i[5:0];
    end
  end

  assign leap = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                      : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);

  always_comb begin
    case (mon)
      5'h02:                      mlast = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: mlast = 6'h30;
      default:                    mlast = 6'h31;
    endcase
  end

  assign mday_end = (mday == mlast);
  assign mon_cy   = day_cy && mday_end;
  assign yr_cy    = mon_cy && (mon == 5'h12);
  assign yr_wrap  = (yr == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 7'h00;
      min  <= 7'h00;
      hr   <= 6'h00;
      wday <= 3'd0;
      mday <= 6'h01;
      mon  <= 5'h01;
      cen  <= 1'b0;
      yr   <= 8'h00;
      h12  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        3'd0: sec  <= wdata[6:0];
        3'd1: min  <= wdata[6:0];
        3'd2: hr   <= wdata[5:0];
        3'd3: wday <= wdata[2:0];
        3'd4: mday <= wdata[5:0];
        3'd5: begin mon <= wdata[4:0]; cen <= wdata[7]; end
        3'd6: yr   <= wdata;
        default: h12 <= wdata[0];
      endcase
    end else if (tick) begin
      sec <= sec_wrap ? 7'h00 : sec_i[6:0];
      if (sec_wrap) min <= (min == 7'h59) ? 7'h00 : min_i[6:0];
      if (min_cy)   hr  <= hr_nx;
      if (day_cy) begin
        wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
        mday <= mday_end ? 6'h01 : mday_i[5:0];
      end
      if (mon_cy) mon <= (mon == 5'h12) ? 5'h01 : mon_i[4:0];
      if (yr_cy) begin
        yr  <= yr_wrap ? 8'h00 : yr_i;
        cen <= cen ^ yr_wrap;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {1'b0, sec};
      3'd1:    rdata = {1'b0, min};
      3'd2:    rdata = {2'b0, hr};
      3'd3:    rdata = {5'b0, wday};
      3'd4:    rdata = {2'b0, mday};
      3'd5:    rdata = {cen, 2'b0, mon};
      3'd6:    rdata = yr;
      default: rdata = {7'b0, h12};
    endcase
  end

endmodule

// File: rtl/bcd_clock_core_chk.sv
module bcd_clock_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic [5:0] hr,
  input logic [2:0] wday,
  input logic [5:0] mday,
  input logic       cen,
  input logic [7:0] yr
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(mday) && $stable(yr))); // R2

  AST_MIN_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick && sec != 7'h59) |=> $stable(min)); // R2

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wday <= 3'd6); // R5

  AST_MDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick) |=> (mday != 6'h00)); // R6

  AST_CEN_ON_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(tick && yr == 8'h99)) |=> $stable(cen)); // R8

  AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (sec == $past(wdata[6:0]))); // R9

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tick && addr != 3'd0) |=> $stable(sec)); // R9

endmodule

bind bcd_clock_core bcd_clock_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sec(sec), .min(min), .hr(hr), .wday(wday), .mday(mday), .cen(cen), .yr(yr)
);

// File: tb/sim_bcd_clock_core.sv
`timescale 1ns/1ps
module sim_bcd_clock_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_clock_core u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  // {mode12, hour, mday, month(bit7=century), year, exp hour, exp mday, exp month, exp year}
  localparam int NV = 18;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 8'h23, 8'h31, 8'h12, 8'h99, 8'h00, 8'h01, 8'h81, 8'h00},
    {1'b0, 8'h23, 8'h28, 8'h02, 8'h23, 8'h00, 8'h01, 8'h03, 8'h23},
    {1'b0, 8'h23, 8'h28, 8'h02, 8'h24, 8'h00, 8'h29, 8'h02, 8'h24},
    {1'b0, 8'h23, 8'h29, 8'h02, 8'h24, 8'h00, 8'h01, 8'h03, 8'h24},
    {1'b0, 8'h23, 8'h30, 8'h04, 8'h10, 8'h00, 8'h01, 8'h05, 8'h10},
    {1'b0, 8'h23, 8'h30, 8'h05, 8'h10, 8'h00, 8'h31, 8'h05, 8'h10},
    {1'b0, 8'h09, 8'h15, 8'h06, 8'h10, 8'h10, 8'h15, 8'h06, 8'h10},
    {1'b1, 8'h11, 8'h15, 8'h06, 8'h10, 8'h32, 8'h15, 8'h06, 8'h10},
    {1'b1, 8'h31, 8'h15, 8'h06, 8'h10, 8'h12, 8'h16, 8'h06, 8'h10},
    {1'b1, 8'h12, 8'h15, 8'h06, 8'h10, 8'h01, 8'h15, 8'h06, 8'h10},
    {1'b1, 8'h29, 8'h15, 8'h06, 8'h10, 8'h30, 8'h15, 8'h06, 8'h10},
    {1'b0, 8'h19, 8'h15, 8'h06, 8'h10, 8'h20, 8'h15, 8'h06, 8'h10},
    {1'b0, 8'h23, 8'h28, 8'h02, 8'h96, 8'h00, 8'h29, 8'h02, 8'h96},
    {1'b0, 8'h23, 8'h29, 8'h02, 8'h00, 8'h00, 8'h01, 8'h03, 8'h00},
    {1'b0, 8'h23, 8'h28, 8'h82, 8'h98, 8'h00, 8'h01, 8'h83, 8'h98},
    {1'b0, 8'h23, 8'h30, 8'h11, 8'h12, 8'h00, 8'h01, 8'h12, 8'h12},
    {1'b0, 8'h23, 8'h31, 8'h92, 8'h99, 8'h00, 8'h01, 8'h01, 8'h00},
    {1'b1, 8'h31, 8'h31, 8'h12, 8'h99, 8'h12, 8'h01, 8'h81, 8'h00}
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rdata, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 3'd0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h00);
    chk("R1", 3'd3, 8'h00); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
    chk("R1", 3'd6, 8'h00); chk("R1", 3'd7, 8'h00);

    // Vector table: R3 R4 R5 R6 R7 R8 one-tick cascades
    for (int v = 0; v < NV; v++) begin
      logic [7:0] hh, dd, mm, yy, eh, ed, em, ey;
      {hh, dd, mm, yy, eh, ed, em, ey} = VEC[v][63:0];
      wr(3'd7, {7'b0, VEC[v][64]});
      wr(3'd2, hh); wr(3'd4, dd); wr(3'd5, mm); wr(3'd6, yy);
      wr(3'd3, 8'h06); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      pulse(1);
      chk("R2", 3'd0, 8'h00);
      chk("R2", 3'd1, 8'h00);
      chk(VEC[v][64] ? "R4" : "R3", 3'd2, eh);
      chk("R5", 3'd3, (ed != dd) ? 8'h00 : 8'h06);
      chk((mm[4:0] == 5'h02) ? "R7" : "R6", 3'd4, ed);
      chk("R8", 3'd5, em);
      chk("R8", 3'd6, ey);
    end

    // R2: BCD digit carry and hold without tick
    wr(3'd7, 8'h00); wr(3'd1, 8'h09); wr(3'd0, 8'h09);
    pulse(1);
    chk("R2", 3'd0, 8'h10);
    repeat (6) @(negedge clk);
    chk("R2", 3'd0, 8'h10);
    wr(3'd0, 8'h59);
    pulse(1);
    chk("R2", 3'd0, 8'h00); chk("R2", 3'd1, 8'h10);
    pulse(60);
    chk("R2", 3'd0, 8'h00); chk("R2", 3'd1, 8'h11);

    // R9: write and tick in the same cycle; the tick is dropped
    wr(3'd0, 8'h59); wr(3'd1, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; tick = 1'b1; addr = 3'd1; wdata = 8'h33;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R9", 3'd0, 8'h59); chk("R9", 3'd1, 8'h33);
    pulse(1);
    chk("R9", 3'd0, 8'h00); chk("R9", 3'd1, 8'h34);

    // R10: control readback and zeroed upper bits
    wr(3'd7, 8'hFF);
    chk("R10", 3'd7, 8'h01);
    wr(3'd3, 8'hFD);
    chk("R10", 3'd3, 8'h05);
    wr(3'd5, 8'hE7);
    chk("R10", 3'd5, 8'h87);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule